// File: doc/BRIEF.md
# Predicated Dataflow Instruction Window

This block is the waiting room in front of one ALU of a dataflow core. It keeps a bank of instruction slots. Each slot holds a two-bit guard mode, a count of the data operands it needs, a left and a right operand register, and a single guard-status bit. Result tokens from the operand network arrive one per cycle. Each token names one slot and one operand position in a compact target code. The block stores data operands with their null and exception tags. For a guard token, the block only records that the token matched the slot's polarity. A guard token of the other polarity leaves the slot untouched, so a slot can be the target of many guard tokens and fire on whichever one matches. This gives an implicit OR.

Each slot has a lifecycle machine with the states Free, Waiting and Fired:
- Allocate moves a slot from Free to Waiting.
- Fire moves it from Waiting to Fired.
- Reallocate moves it from Waiting or Fired back to Waiting.
- Flush returns any slot to Free.

A lowest-index picker chooses among the Waiting slots that are complete. The issue controller has the states Idle and Offer:
- Capture moves Idle to Offer.
- Refill keeps Offer and loads the next slot on a handshake.
- Hold keeps Offer while the ALU stalls.
- Drain moves Offer to Idle.
- Flush forces Idle.

The ALU takes instructions through a valid/ready pair.

Top module: `pdw_window`

## Requirements
- R1: A token target is split into a slot index in bits [TGT_W-1:2] and an operand code in bits [1:0]. The codes are 00 = left, 01 = right, 10 = guard. A token with code 11 is ignored.
- R2: An allocation writes the guard mode and the needed-operand count (0, 1 or 2) into the slot named by `alloc_idx`. It clears that slot's operand and guard status, and the slot enters Waiting. When the slot issues, `issue_idx` carries its index.
- R3: The guard mode codes are 00 = unguarded, 11 = fire on a true guard, 10 = fire on a false guard; code 01 behaves as unguarded. A guard token is true when bit 0 of its data is 1 and its exception flag is 0. A token with the exception flag set counts as false.
- R4: A slot is complete only when three conditions hold: a left operand is present if it needs one or more operands, a right operand is present if it needs two, and a matching guard has been recorded if the slot is guarded.
- R5: A guard token whose polarity does not match is ignored. Any number of guard tokens may target one slot, and a later matching token still makes the slot complete.
- R6: A complete slot is captured into the issue register at the next clock edge, and `issue_valid` rises. The offer stays stable until `issue_ready` is high.
- R7: When several slots are complete, the lowest index is issued first. On a handshake, the next complete slot is captured in the same cycle.
- R8: A slot issues at most once per allocation.
- R9: `flush` returns every slot to Free and drops any pending offer within one cycle. A token in the flush cycle, or a token aimed at a slot that is not Waiting, is ignored.
- R10: The null and exception tags of each operand are issued together with that operand's data.
- R11: After reset, `issue_valid` is low and every slot is Free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| flush | input | 1 | clear all slots and the pending offer |
| alloc_valid | input | 1 | allocate a slot this cycle |
| alloc_idx | input | IDX_W | slot to allocate |
| alloc_mode | input | 2 | guard mode of the new instruction |
| alloc_nops | input | 2 | number of data operands needed |
| tok_valid | input | 1 | token present |
| tok_target | input | IDX_W+2 | slot index and operand code |
| tok_data | input | DATA_W | token value |
| tok_null | input | 1 | null tag of the token |
| tok_exc | input | 1 | exception tag of the token |
| issue_ready | input | 1 | ALU accepts the offer |
| issue_valid | output | 1 | offer present |
| issue_idx | output | IDX_W | slot being issued |
| issue_lhs | output | DATA_W | left operand |
| issue_lhs_null | output | 1 | left null tag |
| issue_lhs_exc | output | 1 | left exception tag |
| issue_rhs | output | DATA_W | right operand |
| issue_rhs_null | output | 1 | right null tag |
| issue_rhs_exc | output | 1 | right exception tag |

## Verification
Two events can meet in one cycle. First, a handshake can retire the current offer in the same cycle that the picker captures the next complete slot. The bench fills three slots while an earlier offer is held, then accepts them one at a time, and expects the indices in ascending order with no gap cycle. Second, a flush can coincide with a token that would complete a slot. The bench issues both in one cycle and then expects no offer at all, including after the missing operand is sent again.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    typedef enum logic [1:0] {
        SLOT_LEFT  = 2'b00,
        SLOT_RIGHT = 2'b01,
        SLOT_PRED  = 2'b10,
        SLOT_RSVD  = 2'b11
    } slot_e;

    typedef enum logic [1:0] {
        PM_NONE     = 2'b00,
        PM_RSVD     = 2'b01,
        PM_ON_FALSE = 2'b10,
        PM_ON_TRUE  = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        ENT_FREE,
        ENT_WAIT,
        ENT_FIRED
    } ent_state_e;

    typedef enum logic {
        ISS_IDLE,
        ISS_OFFER
    } iss_state_e;

    typedef struct packed {
        logic nul;
        logic exc;
    } tag_t;

    // True when a guard token of this value satisfies the given mode.
    function automatic logic pred_hits(input pmode_e mode, input logic lsb, input logic exc);
        logic truth;
        truth = lsb & ~exc;
        case (mode)
            PM_ON_TRUE:  return truth;
            PM_ON_FALSE: return ~truth;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pdw_entry.sv
module pdw_entry
    import pdw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_hit,
    input  pmode_e            alloc_mode,
    input  logic [1:0]        alloc_nops,
    input  logic              tok_hit,
    input  slot_e             tok_slot,
    input  logic [DATA_W-1:0] tok_data,
    input  tag_t              tok_tag,
    input  logic              grant,
    output logic              ready,
    output logic [DATA_W-1:0] lhs_data,
    output tag_t              lhs_tag,
    output logic [DATA_W-1:0] rhs_data,
    output tag_t              rhs_tag
);

    ent_state_e  st_q, st_d;
    pmode_e      mode_q;
    logic [1:0]  need_q;
    logic        lhs_ok_q, rhs_ok_q, prd_ok_q;
    logic        live_tok;

    // Tokens only land on a slot that is waiting.
    assign live_tok = tok_hit && (st_q == ENT_WAIT);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENT_FREE:  if (alloc_hit) st_d = ENT_WAIT;
            ENT_WAIT:  if (alloc_hit) st_d = ENT_WAIT;
                       else if (grant) st_d = ENT_FIRED;
            ENT_FIRED: if (alloc_hit) st_d = ENT_WAIT;
            default:   st_d = ENT_FREE;
        endcase
        if (flush) st_d = ENT_FREE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENT_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= PM_NONE;
            need_q   <= 2'd0;
            lhs_ok_q <= 1'b0;
            rhs_ok_q <= 1'b0;
            prd_ok_q <= 1'b0;
        end else if (flush) begin
            lhs_ok_q <= 1'b0;
            rhs_ok_q <= 1'b0;
            prd_ok_q <= 1'b0;
        end else if (alloc_hit) begin
            mode_q   <= alloc_mode;
            need_q   <= alloc_nops;
            lhs_ok_q <= 1'b0;
            rhs_ok_q <= 1'b0;
            prd_ok_q <= 1'b0;
        end else if (live_tok) begin
            unique case (tok_slot)
                SLOT_LEFT:  lhs_ok_q <= 1'b1;
                SLOT_RIGHT: rhs_ok_q <= 1'b1;
                SLOT_PRED:  if (pred_hits(mode_q, tok_data[0], tok_tag.exc)) prd_ok_q <= 1'b1;
                SLOT_RSVD:  ;
                default:    ;
            endcase
        end
    end

    // Operand payload carries no reset; it is qualified by the status bits.
    always_ff @(posedge clk) begin
        if (live_tok && !flush && !alloc_hit) begin
            if (tok_slot == SLOT_LEFT) begin
                lhs_data <= tok_data;
                lhs_tag  <= tok_tag;
            end
            if (tok_slot == SLOT_RIGHT) begin
                rhs_data <= tok_data;
                rhs_tag  <= tok_tag;
            end
        end
    end

    assign ready = (st_q == ENT_WAIT)
                && ((need_q == 2'd0) || lhs_ok_q)
                && ((need_q <  2'd2) || rhs_ok_q)
                && (!mode_q[1] || prd_ok_q);

endmodule

// File: rtl/pdw_pick.sv
module pdw_pick #(
    parameter int IDX_W = 7,
    localparam int N    = 1 << IDX_W
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so that the lowest requester is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pdw_issue_ctl.sv
module pdw_issue_ctl
    import pdw_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              any_ready,
    input  logic [IDX_W-1:0]  pick_idx,
    input  logic [DATA_W-1:0] sel_lhs,
    input  tag_t              sel_ltag,
    input  logic [DATA_W-1:0] sel_rhs,
    input  tag_t              sel_rtag,
    input  logic              issue_ready,
    output logic              capture,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  issue_idx,
    output logic [DATA_W-1:0] issue_lhs,
    output tag_t              issue_ltag,
    output logic [DATA_W-1:0] issue_rhs,
    output tag_t              issue_rtag
);

    iss_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ISS_IDLE:  if (any_ready) st_d = ISS_OFFER;
            ISS_OFFER: if (issue_ready && !any_ready) st_d = ISS_IDLE;
            default:   st_d = ISS_IDLE;
        endcase
        if (flush) st_d = ISS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ISS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        issue_valid = (st_q == ISS_OFFER);
        capture     = !flush && any_ready && ((st_q == ISS_IDLE) || issue_ready);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_idx  <= '0;
            issue_lhs  <= '0;
            issue_ltag <= '0;
            issue_rhs  <= '0;
            issue_rtag <= '0;
        end else if (capture) begin
            issue_idx  <= pick_idx;
            issue_lhs  <= sel_lhs;
            issue_ltag <= sel_ltag;
            issue_rhs  <= sel_rhs;
            issue_rtag <= sel_rtag;
        end
    end

endmodule

// File: rtl/pdw_window.sv
module pdw_window
    import pdw_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int TGT_W   = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_valid,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [1:0]        alloc_mode,
    input  logic [1:0]        alloc_nops,
    input  logic              tok_valid,
    input  logic [TGT_W-1:0]  tok_target,
    input  logic [DATA_W-1:0] tok_data,
    input  logic              tok_null,
    input  logic              tok_exc,
    input  logic              issue_ready,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  issue_idx,
    output logic [DATA_W-1:0] issue_lhs,
    output logic              issue_lhs_null,
    output logic              issue_lhs_exc,
    output logic [DATA_W-1:0] issue_rhs,
    output logic              issue_rhs_null,
    output logic              issue_rhs_exc
);

    logic [IDX_W-1:0]  tok_idx;
    slot_e             tok_slot;
    tag_t              tok_tag;
    logic [ENTRIES-1:0] ready_vec;
    logic [DATA_W-1:0] e_lhs [ENTRIES];
    logic [DATA_W-1:0] e_rhs [ENTRIES];
    tag_t              e_ltag [ENTRIES];
    tag_t              e_rtag [ENTRIES];
    logic              any_ready, capture;
    logic [IDX_W-1:0]  pick_idx;
    tag_t              out_ltag, out_rtag;

    assign tok_idx  = tok_target[TGT_W-1:2];
    assign tok_slot = slot_e'(tok_target[1:0]);
    assign tok_tag  = '{nul: tok_null, exc: tok_exc};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        pdw_entry #(.DATA_W(DATA_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .alloc_hit (alloc_valid && (alloc_idx == IDX_W'(g))),
            .alloc_mode(pmode_e'(alloc_mode)),
            .alloc_nops(alloc_nops),
            .tok_hit   (tok_valid && (tok_idx == IDX_W'(g))),
            .tok_slot  (tok_slot),
            .tok_data  (tok_data),
            .tok_tag   (tok_tag),
            .grant     (capture && (pick_idx == IDX_W'(g))),
            .ready     (ready_vec[g]),
            .lhs_data  (e_lhs[g]),
            .lhs_tag   (e_ltag[g]),
            .rhs_data  (e_rhs[g]),
            .rhs_tag   (e_rtag[g])
        );
    end

    pdw_pick #(.IDX_W(IDX_W)) u_pick (
        .req(ready_vec),
        .any(any_ready),
        .idx(pick_idx)
    );

    pdw_issue_ctl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .any_ready  (any_ready),
        .pick_idx   (pick_idx),
        .sel_lhs    (e_lhs[pick_idx]),
        .sel_ltag   (e_ltag[pick_idx]),
        .sel_rhs    (e_rhs[pick_idx]),
        .sel_rtag   (e_rtag[pick_idx]),
        .issue_ready(issue_ready),
        .capture    (capture),
        .issue_valid(issue_valid),
        .issue_idx  (issue_idx),
        .issue_lhs  (issue_lhs),
        .issue_ltag (out_ltag),
        .issue_rhs  (issue_rhs),
        .issue_rtag (out_rtag)
    );

    assign issue_lhs_null = out_ltag.nul;
    assign issue_lhs_exc  = out_ltag.exc;
    assign issue_rhs_null = out_rtag.nul;
    assign issue_rhs_exc  = out_rtag.exc;

endmodule

// File: rtl/pdw_window_chk.sv
module pdw_window_chk
    import pdw_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int TGT_W   = IDX_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              alloc_valid,
    input logic [IDX_W-1:0]  alloc_idx,
    input logic [1:0]        alloc_mode,
    input logic [1:0]        alloc_nops,
    input logic              tok_valid,
    input logic [TGT_W-1:0]  tok_target,
    input logic              tok_lsb,
    input logic              tok_exc,
    input logic              issue_ready,
    input logic              issue_valid,
    input logic [IDX_W-1:0]  issue_idx,
    input logic [DATA_W-1:0] issue_lhs,
    input logic [DATA_W-1:0] issue_rhs
);

    logic [1:0]         m_mode [ENTRIES];
    logic [1:0]         m_need [ENTRIES];
    logic [ENTRIES-1:0] m_live, m_fired, m_l, m_r, m_p, m_ok;
    logic               hs, prev_valid, prev_hs, new_offer;

    assign hs        = issue_valid && issue_ready;
    assign new_offer = issue_valid && (!prev_valid || prev_hs);

    // Port-level shadow of what each slot has received.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_live <= '0; m_fired <= '0; m_l <= '0; m_r <= '0; m_p <= '0;
            prev_valid <= 1'b0; prev_hs <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                m_mode[i] <= 2'b00;
                m_need[i] <= 2'd0;
            end
        end else begin
            prev_valid <= issue_valid && !flush;
            prev_hs    <= hs;
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush) begin
                    m_live[i] <= 1'b0; m_fired[i] <= 1'b0;
                    m_l[i] <= 1'b0; m_r[i] <= 1'b0; m_p[i] <= 1'b0;
                end else if (alloc_valid && alloc_idx == IDX_W'(i)) begin
                    m_live[i] <= 1'b1; m_fired[i] <= 1'b0;
                    m_l[i] <= 1'b0; m_r[i] <= 1'b0; m_p[i] <= 1'b0;
                    m_mode[i] <= alloc_mode;
                    m_need[i] <= alloc_nops;
                end else begin
                    if (hs && issue_idx == IDX_W'(i)) m_fired[i] <= 1'b1;
                    if (tok_valid && tok_target[TGT_W-1:2] == IDX_W'(i) && m_live[i]) begin
                        if (tok_target[1:0] == 2'b00) m_l[i] <= 1'b1;
                        if (tok_target[1:0] == 2'b01) m_r[i] <= 1'b1;
                        if (tok_target[1:0] == 2'b10 &&
                            pred_hits(pmode_e'(m_mode[i]), tok_lsb, tok_exc)) m_p[i] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_ok[i] = m_live[i]
                   && (m_need[i] == 2'd0 || m_l[i])
                   && (m_need[i] <  2'd2 || m_r[i])
                   && (!m_mode[i][1] || m_p[i]);
        end
    end

    // R4: an offered slot had every operand and a matching guard
    a_r4_offer_complete: assert property (@(posedge clk) disable iff (!rst_n || flush)
        new_offer |-> m_ok[issue_idx]);

    // R6: a stalled offer holds its contents
    a_r6_offer_hold: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (issue_valid && !issue_ready) |=> (issue_valid && $stable(issue_idx)
                                           && $stable(issue_lhs) && $stable(issue_rhs)));

    // R8: a slot is accepted at most once per allocation
    a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> !m_fired[issue_idx]);

    // R9: flush drops the pending offer
    a_r9_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !issue_valid);

endmodule

bind pdw_window pdw_window_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .alloc_valid(alloc_valid),
    .alloc_idx  (alloc_idx),
    .alloc_mode (alloc_mode),
    .alloc_nops (alloc_nops),
    .tok_valid  (tok_valid),
    .tok_target (tok_target),
    .tok_lsb    (tok_data[0]),
    .tok_exc    (tok_exc),
    .issue_ready(issue_ready),
    .issue_valid(issue_valid),
    .issue_idx  (issue_idx),
    .issue_lhs  (issue_lhs),
    .issue_rhs  (issue_rhs)
);

// File: tb/tb_pdw_window.sv
module tb_pdw_window;

    localparam int IDX_W  = 3;
    localparam int DATA_W = 8;
    localparam int TGT_W  = IDX_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [IDX_W-1:0]  alloc_idx = '0;
    logic [1:0]        alloc_mode = '0;
    logic [1:0]        alloc_nops = '0;
    logic              tok_valid = 1'b0;
    logic [TGT_W-1:0]  tok_target = '0;
    logic [DATA_W-1:0] tok_data = '0;
    logic              tok_null = 1'b0;
    logic              tok_exc = 1'b0;
    logic              issue_ready = 1'b0;
    logic              issue_valid;
    logic [IDX_W-1:0]  issue_idx;
    logic [DATA_W-1:0] issue_lhs, issue_rhs;
    logic              issue_lhs_null, issue_lhs_exc, issue_rhs_null, issue_rhs_exc;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pdw_window #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut (.*);

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_alloc(input int idx, input int mode, input int nops);
        alloc_valid = 1'b1;
        alloc_idx   = IDX_W'(idx);
        alloc_mode  = 2'(mode);
        alloc_nops  = 2'(nops);
        cyc();
        alloc_valid = 1'b0;
    endtask

    task automatic send(input int idx, input int slot, input int data, input bit nul, input bit exc);
        tok_valid  = 1'b1;
        tok_target = {IDX_W'(idx), 2'(slot)};
        tok_data   = DATA_W'(data);
        tok_null   = nul;
        tok_exc    = exc;
        cyc();
        tok_valid  = 1'b0;
    endtask

    task automatic accept();
        issue_ready = 1'b1;
        cyc();
        issue_ready = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        cyc();
        flush = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        expect_eq("R11", "issue_valid after reset", int'(issue_valid), 0);

        // R2 R3 R4 R10 R8: sweep guard mode, guard value, exception flag, operand count
        for (int m = 0; m < 3; m++) begin
            for (int v = 0; v < 2; v++) begin
                for (int x = 0; x < 2; x++) begin
                    for (int n = 0; n < 3; n++) begin
                        int c, idx, mode, ld, rd;
                        bit truth, fire;
                        c    = ((m * 2 + v) * 2 + x) * 3 + n;
                        idx  = c % 8;
                        mode = (m == 0) ? 0 : ((m == 1) ? 2 : 3);
                        ld   = (c * 7 + 3) % 256;
                        rd   = (c * 11 + 5) % 256;
                        do_alloc(idx, mode, n);
                        if (n >= 1) send(idx, 0, ld, c[0], c[1]);
                        if (n == 2) send(idx, 1, rd, c[1], c[0]);
                        send(idx, 2, (c * 2 + v) % 256, 1'b0, x[0]);
                        cyc();
                        cyc();
                        truth = (v == 1) && (x == 0);
                        fire  = (mode == 0) || ((mode == 3) ? truth : !truth);
                        expect_eq("R4", "offer vs guard and operands", int'(issue_valid), int'(fire));
                        if (fire && issue_valid) begin
                            expect_eq("R2", "issued slot index", int'(issue_idx), idx);
                            if (n >= 1) begin
                                expect_eq("R10", "left data", int'(issue_lhs), ld);
                                expect_eq("R10", "left null tag", int'(issue_lhs_null), int'(c[0]));
                                expect_eq("R10", "left exc tag", int'(issue_lhs_exc), int'(c[1]));
                            end
                            if (n == 2) begin
                                expect_eq("R10", "right data", int'(issue_rhs), rd);
                                expect_eq("R10", "right null tag", int'(issue_rhs_null), int'(c[1]));
                                expect_eq("R10", "right exc tag", int'(issue_rhs_exc), int'(c[0]));
                            end
                            accept();
                            cyc();
                            expect_eq("R8", "no second offer", int'(issue_valid), 0);
                        end
                    end
                end
            end
        end
        do_flush();

        // R5 R3: implicit OR on a true-guarded slot
        do_alloc(3, 3, 0);
        send(3, 2, 0, 1'b0, 1'b0);
        cyc(); cyc();
        expect_eq("R5", "false guard ignored", int'(issue_valid), 0);
        send(3, 2, 1, 1'b0, 1'b1);
        cyc(); cyc();
        expect_eq("R3", "exception guard counts false", int'(issue_valid), 0);
        send(3, 2, 1, 1'b0, 1'b0);
        cyc();
        expect_eq("R5", "matching guard after mismatches", int'(issue_valid), 1);
        expect_eq("R5", "slot index", int'(issue_idx), 3);
        accept();
        do_alloc(4, 2, 0);
        send(4, 2, 1, 1'b0, 1'b0);
        cyc(); cyc();
        expect_eq("R5", "true guard ignored on false slot", int'(issue_valid), 0);
        send(4, 2, 6, 1'b0, 1'b0);
        cyc();
        expect_eq("R5", "false guard fires false slot", int'(issue_valid), 1);
        accept();

        // R1: reserved operand code
        do_alloc(1, 0, 1);
        send(1, 3, 85, 1'b0, 1'b0);
        cyc(); cyc();
        expect_eq("R1", "reserved code ignored", int'(issue_valid), 0);
        send(1, 0, 166, 1'b0, 1'b0);
        cyc();
        expect_eq("R1", "left code lands", int'(issue_valid), 1);
        expect_eq("R1", "left data", int'(issue_lhs), 166);
        accept();

        // R6 R7: hold, then ascending drain with same-cycle refill
        do_alloc(7, 0, 0);
        cyc();
        expect_eq("R6", "offer present", int'(issue_valid), 1);
        expect_eq("R6", "offer index", int'(issue_idx), 7);
        do_alloc(5, 0, 0);
        do_alloc(2, 0, 0);
        do_alloc(6, 0, 0);
        cyc();
        expect_eq("R6", "held index", int'(issue_idx), 7);
        accept();
        expect_eq("R7", "refill valid", int'(issue_valid), 1);
        expect_eq("R7", "lowest first", int'(issue_idx), 2);
        accept();
        expect_eq("R7", "second", int'(issue_idx), 5);
        accept();
        expect_eq("R7", "third", int'(issue_idx), 6);
        accept();
        expect_eq("R7", "drained", int'(issue_valid), 0);

        // R9: flush with a simultaneous completing token
        do_alloc(0, 0, 0);
        do_alloc(2, 0, 2);
        send(2, 0, 9, 1'b0, 1'b0);
        cyc();
        expect_eq("R9", "offer before flush", int'(issue_valid), 1);
        flush      = 1'b1;
        tok_valid  = 1'b1;
        tok_target = {IDX_W'(2), 2'b01};
        tok_data   = 8'd4;
        cyc();
        flush      = 1'b0;
        tok_valid  = 1'b0;
        cyc();
        expect_eq("R9", "offer dropped", int'(issue_valid), 0);
        send(2, 1, 4, 1'b0, 1'b0);
        send(5, 0, 4, 1'b0, 1'b0);
        cyc(); cyc();
        expect_eq("R9", "freed slots ignore tokens", int'(issue_valid), 0);
        do_alloc(2, 0, 0);
        cyc();
        expect_eq("R9", "slot usable after flush", int'(issue_valid), 1);
        expect_eq("R9", "slot index after flush", int'(issue_idx), 2);
        accept();

        summary();
        $finish;
    end

endmodule